// File: doc/BRIEF.md
# 1-Wire Time Slot Generator

This block is the timing engine of a single-wire bus master. The host presents a two-bit command together with a speed select and pulses a start strobe. The block then plays one complete time slot on an open-drain line. It pulls the line low through a drive enable and samples the level that comes back. When the slot is over it raises a one-cycle done pulse carrying a one-bit result. Three kinds of slot exist: a read or write-1 bit, a write-0 bit, and a bus reset followed by presence detection. Each kind runs at normal speed or at overdrive speed.

All durations are counted in ticks of a one-microsecond enable input, so the system clock frequency has no effect on bus timing. A reset keeps the master occupied for a minimum window measured from the first falling edge. This guarantees the idle-high recovery after a presence pulse.

A line can still be low when the reset pulse ends, either because a device is signalling an alarm or because the line is shorted. In that case the block waits a bounded time for the line to rise. If the line rises, presence monitoring continues. If the wait times out, the line is flagged as shorted and the slot ends.

Top module: `owire_slot_gen`

## Requirements
- R1: Out of reset, `lineDrvLow` is 0, `slotDone` is 0 and `lineShorted` is 0.
- R2: At a start, the command is decoded from (`cmdData`,`cmdRst`) as follows: (1,1) selects a read/write-1 bit slot, (0,1) selects a write-0 slot and (1,0) selects a bus reset. The value (0,0) is ignored: the line is not driven and no done pulse follows.
- R3: For a read/write-1 slot, the line is driven low for 6 ticks in normal mode or 1 tick in overdrive (`odSel`=1). `slotResult` is the line level sampled on tick 8 in normal mode or tick 2 in overdrive. `slotDone` rises 60 ticks after the start in normal mode or 6 ticks in overdrive.
- R4: A write-0 slot holds the line low for the whole slot (60 ticks normal, 6 ticks overdrive) and reports `slotResult`=0 whatever the line does.
- R5: A bus reset drives the line low for 480 ticks in normal mode or 48 ticks in overdrive.
- R6: After the line is seen high following the reset pulse, any low seen within the next 70 ticks (7 in overdrive) gives `slotResult`=0. If no low is seen, `slotResult`=1.
- R7: Reset done comes no earlier than 960 ticks after the start (96 in overdrive). It also comes no earlier than 480 ticks (48 in overdrive) after the line was seen high.
- R8: If the line is still low when the reset pulse ends, the block waits up to 3840 ticks for it to rise. On timeout it sets `lineShorted`=1 with `slotResult`=0 and signals done. If the line rises within that time, presence monitoring proceeds as in R6 and R7.
- R9: A start strobe while a slot is in progress is ignored and does not alter that slot.
- R10: Slot timing advances only on cycles where `usTick` is 1.
- R11: `slotDone` lasts exactly one clock cycle, and `lineShorted` is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-microsecond timing enable |
| startStb | input | 1 | Start strobe, one cycle |
| cmdData | input | 1 | Command bit: data level |
| cmdRst | input | 1 | Command bit: reset select, active low |
| odSel | input | 1 | 1 selects overdrive timing for the slot |
| lineIn | input | 1 | Level returned by the bus line |
| lineDrvLow | output | 1 | Open-drain enable, 1 pulls the line low |
| slotDone | output | 1 | One-cycle pulse at the end of a slot |
| slotResult | output | 1 | Sampled bit or presence result, held until next start |
| lineShorted | output | 1 | Set when a reset times out with the line low |

## Verification
The bench sweeps the moment a device releases the line across every tick of a bit slot at both speeds. A sample taken one tick early or late therefore flips the result at the wrong release point. For resets it places presence pulses just inside and just outside the detection window, and it holds the line low for stretches that end just before the stuck-line timeout, exactly on it, and past it. An off-by-one in the stuck wait or in the release check would report a short when the line actually recovered, or the reverse. A slowed tick and a mid-slot start strobe are used to expose timing that runs on the clock instead of the tick, and a second slot that gets started by mistake.

// File: rtl/owsPkg.sv
package owsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT,
    ST_RLOW,
    ST_RREL,
    ST_RWAIT,
    ST_RPRES
  } owsState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrSlot;   // slot start: clear counters and flags
    logic clrPhase;  // restart the phase counter
    logic drvOn;     // begin pulling the line low
    logic drvOff;    // release the line
    logic capLine;   // capture the line level as result
    logic resZero;   // force result low
    logic resOne;    // preset result high
    logic setShort;  // flag a shorted line
    logic fireDone;  // slot complete
  } owsStrobe_t;

endpackage

// File: rtl/owsDatapath.sv
module owsDatapath
  import owsPkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             lineIn,
  input  owsStrobe_t       strb,
  output logic [CNT_W-1:0] slotCnt,
  output logic [CNT_W-1:0] phaseCnt,
  output logic             lineQ,
  output logic             lineDrvLow,
  output logic             slotDone,
  output logic             slotResult,
  output logic             lineShorted
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // optional input synchronizer, idle level high
  generate
    if (SYNC_STAGES == 0) begin : gNoSync
      assign lineQ = lineIn;
    end else begin : gSync
      logic [SYNC_STAGES-1:0] syncQ;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : gStage
        if (i == 0) begin : gFirst
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[0] <= 1'b1;
            else       syncQ[0] <= lineIn;
          end
        end else begin : gNext
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[i] <= 1'b1;
            else       syncQ[i] <= syncQ[i-1];
          end
        end
      end
      assign lineQ = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // tick counters, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (strb.clrSlot) begin
      slotCnt <= '0;
    end else if (usTick && slotCnt != CNT_MAX) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.clrSlot || strb.clrPhase) begin
      phaseCnt <= '0;
    end else if (usTick && phaseCnt != CNT_MAX) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // open-drain enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lineDrvLow <= 1'b0;
    else if (strb.drvOn)  lineDrvLow <= 1'b1;
    else if (strb.drvOff) lineDrvLow <= 1'b0;
  end

  // result bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             slotResult <= 1'b1;
    else if (strb.resOne)  slotResult <= 1'b1;
    else if (strb.resZero) slotResult <= 1'b0;
    else if (strb.capLine) slotResult <= lineQ;
  end

  // short flag and done pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineShorted <= 1'b0;
      slotDone    <= 1'b0;
    end else begin
      slotDone <= strb.fireDone;
      if (strb.clrSlot)       lineShorted <= 1'b0;
      else if (strb.setShort) lineShorted <= 1'b1;
    end
  end

  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !strb.clrSlot) |=> $stable(slotCnt));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotDone |=> !slotDone);

  // R8
  short_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineShorted) |-> (slotDone && !slotResult));

endmodule

// File: rtl/owsControl.sv
module owsControl
  import owsPkg::*;
#(
  parameter int CNT_W      = 13,
  parameter int N_BIT_LOW  = 6,
  parameter int N_BIT_SMP  = 8,
  parameter int N_BIT_SLOT = 60,
  parameter int N_RST_LOW  = 480,
  parameter int N_RST_MIN  = 960,
  parameter int N_PRES_WIN = 70,
  parameter int N_RST_TAIL = 480,
  parameter int O_BIT_LOW  = 1,
  parameter int O_BIT_SMP  = 2,
  parameter int O_BIT_SLOT = 6,
  parameter int O_RST_LOW  = 48,
  parameter int O_RST_MIN  = 96,
  parameter int O_PRES_WIN = 7,
  parameter int O_RST_TAIL = 48,
  parameter int STUCK_WAIT = 3840
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             startStb,
  input  logic             cmdData,
  input  logic             cmdRst,
  input  logic             odSel,
  input  logic             lineQ,
  input  logic [CNT_W-1:0] slotCnt,
  input  logic [CNT_W-1:0] phaseCnt,
  output owsStrobe_t       strb,
  output owsState_e        stateQ,
  output logic             writeZeroQ
);

  // limits stored minus one: an event fires on the tick that reaches the count
  localparam logic [CNT_W-1:0] NB_LOW_M1  = CNT_W'(N_BIT_LOW - 1);
  localparam logic [CNT_W-1:0] NB_SMP_M1  = CNT_W'(N_BIT_SMP - 1);
  localparam logic [CNT_W-1:0] NB_SLOT_M1 = CNT_W'(N_BIT_SLOT - 1);
  localparam logic [CNT_W-1:0] NR_LOW_M1  = CNT_W'(N_RST_LOW - 1);
  localparam logic [CNT_W-1:0] NR_MIN_M1  = CNT_W'(N_RST_MIN - 1);
  localparam logic [CNT_W-1:0] NR_WIN     = CNT_W'(N_PRES_WIN);
  localparam logic [CNT_W-1:0] NR_TAIL_M1 = CNT_W'(N_RST_TAIL - 1);
  localparam logic [CNT_W-1:0] OB_LOW_M1  = CNT_W'(O_BIT_LOW - 1);
  localparam logic [CNT_W-1:0] OB_SMP_M1  = CNT_W'(O_BIT_SMP - 1);
  localparam logic [CNT_W-1:0] OB_SLOT_M1 = CNT_W'(O_BIT_SLOT - 1);
  localparam logic [CNT_W-1:0] OR_LOW_M1  = CNT_W'(O_RST_LOW - 1);
  localparam logic [CNT_W-1:0] OR_MIN_M1  = CNT_W'(O_RST_MIN - 1);
  localparam logic [CNT_W-1:0] OR_WIN     = CNT_W'(O_PRES_WIN);
  localparam logic [CNT_W-1:0] OR_TAIL_M1 = CNT_W'(O_RST_TAIL - 1);
  localparam logic [CNT_W-1:0] STUCK_M1   = CNT_W'(STUCK_WAIT - 1);

  owsState_e stateD;
  logic      odQ;

  // limits of the speed latched at the start
  logic [CNT_W-1:0] bitLowM1, bitSmpM1, bitSlotM1;
  logic [CNT_W-1:0] rstLowM1, rstMinM1, presWin, rstTailM1;

  always_comb begin
    bitLowM1  = odQ ? OB_LOW_M1  : NB_LOW_M1;
    bitSmpM1  = odQ ? OB_SMP_M1  : NB_SMP_M1;
    bitSlotM1 = odQ ? OB_SLOT_M1 : NB_SLOT_M1;
    rstLowM1  = odQ ? OR_LOW_M1  : NR_LOW_M1;
    rstMinM1  = odQ ? OR_MIN_M1  : NR_MIN_M1;
    presWin   = odQ ? OR_WIN     : NR_WIN;
    rstTailM1 = odQ ? OR_TAIL_M1 : NR_TAIL_M1;
  end

  logic cmdValid, cmdIsReset;
  assign cmdValid   = cmdData | cmdRst;
  assign cmdIsReset = cmdData & ~cmdRst;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startStb && cmdValid) begin
          strb.clrSlot = 1'b1;
          strb.drvOn   = 1'b1;
          strb.resOne  = 1'b1;
          stateD       = cmdIsReset ? ST_RLOW : ST_BIT;
        end
      end
      ST_BIT: begin
        if (usTick) begin
          if (!writeZeroQ && slotCnt == bitLowM1) strb.drvOff = 1'b1;
          if (slotCnt == bitSmpM1) begin
            if (writeZeroQ) strb.resZero = 1'b1;
            else            strb.capLine = 1'b1;
          end
          if (slotCnt == bitSlotM1) begin
            strb.drvOff   = 1'b1;
            strb.fireDone = 1'b1;
            stateD        = ST_IDLE;
          end
        end
      end
      ST_RLOW: begin
        if (usTick && slotCnt == rstLowM1) begin
          strb.drvOff = 1'b1;
          stateD      = ST_RREL;
        end
      end
      ST_RREL: begin
        if (usTick) begin
          strb.clrPhase = 1'b1;
          stateD        = lineQ ? ST_RPRES : ST_RWAIT;
        end
      end
      ST_RWAIT: begin
        if (usTick) begin
          if (lineQ) begin
            strb.clrPhase = 1'b1;
            stateD        = ST_RPRES;
          end else if (phaseCnt == STUCK_M1) begin
            strb.setShort = 1'b1;
            strb.resZero  = 1'b1;
            strb.fireDone = 1'b1;
            stateD        = ST_IDLE;
          end
        end
      end
      ST_RPRES: begin
        if (usTick) begin
          if (phaseCnt < presWin && !lineQ) strb.resZero = 1'b1;
          if (phaseCnt >= rstTailM1 && slotCnt >= rstMinM1) begin
            strb.fireDone = 1'b1;
            stateD        = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      odQ        <= 1'b0;
      writeZeroQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && startStb && cmdValid) begin
        odQ        <= odSel;
        writeZeroQ <= ~cmdData;
      end
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && startStb) |=> (stateQ != ST_IDLE || $past(strb.fireDone)));

  // R7
  reset_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RPRES && strb.fireDone) |-> (slotCnt >= rstMinM1));

endmodule

// File: rtl/owire_slot_gen.sv
module owire_slot_gen
  import owsPkg::*;
#(
  parameter int N_BIT_LOW   = 6,
  parameter int N_BIT_SMP   = 8,
  parameter int N_BIT_SLOT  = 60,
  parameter int N_RST_LOW   = 480,
  parameter int N_RST_MIN   = 960,
  parameter int N_PRES_WIN  = 70,
  parameter int N_RST_TAIL  = 480,
  parameter int O_BIT_LOW   = 1,
  parameter int O_BIT_SMP   = 2,
  parameter int O_BIT_SLOT  = 6,
  parameter int O_RST_LOW   = 48,
  parameter int O_RST_MIN   = 96,
  parameter int O_PRES_WIN  = 7,
  parameter int O_RST_TAIL  = 48,
  parameter int STUCK_WAIT  = 3840,
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic startStb,
  input  logic cmdData,
  input  logic cmdRst,
  input  logic odSel,
  input  logic lineIn,
  output logic lineDrvLow,
  output logic slotDone,
  output logic slotResult,
  output logic lineShorted
);

  localparam int CNT_W = $clog2(N_RST_LOW + STUCK_WAIT + N_RST_TAIL + N_RST_MIN + 4);

  owsStrobe_t       strb;
  owsState_e        ctrlState;
  logic             writeZero;
  logic [CNT_W-1:0] slotCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic             lineQ;

  owsControl #(
    .CNT_W(CNT_W),
    .N_BIT_LOW(N_BIT_LOW), .N_BIT_SMP(N_BIT_SMP), .N_BIT_SLOT(N_BIT_SLOT),
    .N_RST_LOW(N_RST_LOW), .N_RST_MIN(N_RST_MIN), .N_PRES_WIN(N_PRES_WIN),
    .N_RST_TAIL(N_RST_TAIL),
    .O_BIT_LOW(O_BIT_LOW), .O_BIT_SMP(O_BIT_SMP), .O_BIT_SLOT(O_BIT_SLOT),
    .O_RST_LOW(O_RST_LOW), .O_RST_MIN(O_RST_MIN), .O_PRES_WIN(O_PRES_WIN),
    .O_RST_TAIL(O_RST_TAIL), .STUCK_WAIT(STUCK_WAIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startStb(startStb),
    .cmdData(cmdData), .cmdRst(cmdRst), .odSel(odSel), .lineQ(lineQ),
    .slotCnt(slotCnt), .phaseCnt(phaseCnt), .strb(strb),
    .stateQ(ctrlState), .writeZeroQ(writeZero)
  );

  owsDatapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineIn(lineIn), .strb(strb),
    .slotCnt(slotCnt), .phaseCnt(phaseCnt), .lineQ(lineQ),
    .lineDrvLow(lineDrvLow), .slotDone(slotDone), .slotResult(slotResult),
    .lineShorted(lineShorted)
  );

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDrvLow |-> (ctrlState != ST_IDLE));

  // R5
  reset_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_RLOW) |-> lineDrvLow);

  // R4
  write_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_BIT && writeZero) |-> lineDrvLow);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE && !(cmdData || cmdRst)) |=> (ctrlState == ST_IDLE));

endmodule

// File: tb/sim_owire_slot_gen.sv
module sim_owire_slot_gen;

  localparam int NL = 6,  NS = 8,  NSL = 60, NR = 480, NRM = 960, NW = 70, NT = 480;
  localparam int OL = 1,  OS = 2,  OSL = 6,  OR = 48,  ORM = 96,  OW = 7,  OT = 48;
  localparam int STK = 3840;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic startStb = 1'b0;
  logic cmdData = 1'b1;
  logic cmdRst = 1'b1;
  logic odSel = 1'b0;
  logic devLow = 1'b0;
  logic lineDrvLow, slotDone, slotResult, lineShorted;
  logic lineW;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int tickDiv = 1;
  int divCnt = 0;

  assign lineW = !(lineDrvLow || devLow);

  always #4 clk = ~clk;

  owire_slot_gen u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startStb(startStb),
    .cmdData(cmdData), .cmdRst(cmdRst), .odSel(odSel), .lineIn(lineW),
    .lineDrvLow(lineDrvLow), .slotDone(slotDone), .slotResult(slotResult),
    .lineShorted(lineShorted)
  );

  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) begin
      divCnt = 0;
      usTick = 1'b1;
    end else begin
      divCnt = divCnt + 1;
      usTick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  // device holds line low for ticks n < holdX and for n in [pA,pB)
  // injN: tick at which a second start strobe is pulsed (-1 for none)
  task automatic runSlot(input logic d, input logic r, input logic od,
                         input int holdX, input int pA, input int pB, input int injN,
                         output int nDone, output int lowCnt, output int res,
                         output int sh, output int doneAfter);
    int cyc;
    bit got;
    @(negedge clk);
    cmdData = d; cmdRst = r; odSel = od; startStb = 1'b1;
    @(posedge clk);
    nDone = 0; lowCnt = 0; cyc = 0; got = 0;
    while (!got && cyc < 20000) begin
      @(negedge clk);
      startStb = 1'b0;
      if (nDone == injN) begin
        startStb = 1'b1; cmdData = 1'b1; cmdRst = 1'b0;
      end
      devLow = (nDone < holdX) || (nDone >= pA && nDone < pB);
      if (lineDrvLow) lowCnt++;
      if (slotDone) begin
        got = 1;
      end else begin
        @(posedge clk);
        if (usTick) nDone++;
        cyc++;
      end
    end
    res = slotResult;
    sh = lineShorted;
    if (!got) nDone = -1;
    @(negedge clk);
    startStb = 1'b0;
    devLow = 1'b0;
    doneAfter = slotDone;
  endtask

  task automatic bitCase(input string tag, input logic w0, input logic od, input int k,
                         input int injN, input bit chkLow);
    int dn, lw, rs, sh, da;
    int eSl, eS, eL, eR;
    eSl = od ? OSL : NSL;
    eS  = od ? OS : NS;
    eL  = od ? OL : NL;
    eR  = w0 ? 0 : ((k < eS) ? 1 : 0);
    runSlot(!w0, 1'b1, od, k, 0, 0, injN, dn, lw, rs, sh, da);
    chk({tag, " done tick"}, dn, eSl);
    chk({tag, " result"}, rs, eR);
    if (chkLow) chk({tag, " low cycles"}, lw, w0 ? eSl : eL);
  endtask

  task automatic rstCase(input string tag, input logic od, input int holdX,
                         input int pA, input int pB, input bit chkLow);
    int dn, lw, rs, sh, da;
    int rL, rM, win, tl, e, eDn, eRs, eSh;
    rL  = od ? OR : NR;
    rM  = od ? ORM : NRM;
    win = od ? OW : NW;
    tl  = od ? OT : NT;
    if (holdX > rL + STK) begin
      eSh = 1; eRs = 0; eDn = rL + 1 + STK;
    end else begin
      eSh = 0;
      e = (holdX <= rL) ? rL + 1 : holdX + 1;
      eDn = (e + tl > rM) ? e + tl : rM;
      eRs = (pA < pB && pA < e + win && pB > e) ? 0 : 1;
    end
    runSlot(1'b1, 1'b0, od, holdX, pA, pB, -1, dn, lw, rs, sh, da);
    chk({tag, " done tick"}, dn, eDn);
    chk({tag, " result"}, rs, eRs);
    chk({tag, " shorted"}, sh, eSh);
    if (chkLow) chk({tag, " low cycles"}, lw, rL);
    chk("R11 done one cycle", da, 0);
  endtask

  initial begin
    int lw, dc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 drive in reset", lineDrvLow, 0);
    chk("R1 done in reset", slotDone, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 drive after reset", lineDrvLow, 0);
    chk("R1 short after reset", lineShorted, 0);

    // R2 command 00 is ignored at both speeds
    for (int od = 0; od < 2; od++) begin
      @(negedge clk);
      cmdData = 1'b0; cmdRst = 1'b0; odSel = od[0]; startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
      lw = 0; dc = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (lineDrvLow) lw++;
        if (slotDone) dc++;
      end
      chk("R2 idle command drive", lw, 0);
      chk("R2 idle command done", dc, 0);
    end

    // R3 read sweep, normal and overdrive
    for (int k = 0; k <= NSL + 2; k++) bitCase("R3 normal read", 1'b0, 1'b0, k, -1, 1'b1);
    for (int k = 0; k <= OSL + 2; k++) bitCase("R3 od read", 1'b0, 1'b1, k, -1, 1'b1);

    // R4 write-0, line otherwise idle high
    bitCase("R4 normal write0", 1'b1, 1'b0, 0, -1, 1'b1);
    bitCase("R4 od write0", 1'b1, 1'b1, 0, -1, 1'b1);

    // R5 R6 R7 normal resets
    rstCase("R6 no device", 1'b0, 0, 0, 0, 1'b1);
    rstCase("R6 presence early", 1'b0, 0, NR + 1 + 15, NR + 1 + 75, 1'b1);
    rstCase("R6 presence last tick", 1'b0, 0, NR + 1 + NW - 1, NR + 1 + NW + 10, 1'b1);
    rstCase("R6 presence too late", 1'b0, 0, NR + 1 + NW, NR + 1 + NW + 10, 1'b1);
    rstCase("R7 od no device", 1'b1, 0, 0, 0, 1'b1);
    rstCase("R6 od presence", 1'b1, 0, OR + 3, OR + 12, 1'b1);
    rstCase("R6 od presence too late", 1'b1, 0, OR + 1 + OW, OR + 20, 1'b1);

    // R8 stuck-low line
    rstCase("R8 alarm then presence", 1'b0, 600, 621, 700, 1'b1);
    rstCase("R8 rises on last wait tick", 1'b0, NR + STK, 0, 0, 1'b1);
    rstCase("R8 short timeout", 1'b0, NR + STK + 1, 0, 0, 1'b1);
    bitCase("R11 short cleared by start", 1'b0, 1'b0, 0, -1, 1'b1);
    chk("R11 short flag cleared", lineShorted, 0);
    rstCase("R8 od short", 1'b1, OR + STK + 1, 0, 0, 1'b1);

    // R9 start strobe mid-slot
    bitCase("R9 normal busy start", 1'b0, 1'b0, 20, 20, 1'b1);
    bitCase("R9 write0 busy start", 1'b1, 1'b0, 0, 3, 1'b1);
    lw = 0; dc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (lineDrvLow) lw++;
      if (slotDone) dc++;
    end
    chk("R9 no follow-on slot drive", lw, 0);
    chk("R9 no follow-on slot done", dc, 0);

    // R10 slowed tick
    tickDiv = 3;
    bitCase("R10 slow read high", 1'b0, 1'b0, NS - 1, -1, 1'b0);
    bitCase("R10 slow read low", 1'b0, 1'b0, NS, -1, 1'b0);
    bitCase("R10 slow od read", 1'b0, 1'b1, OS, -1, 1'b0);
    rstCase("R10 slow reset presence", 1'b0, 0, NR + 20, NR + 80, 1'b0);
    tickDiv = 1;

    finishRun();
  end

endmodule